// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block is the digital guard that sits in front of a battery-backed static memory. It watches two supply comparator flags. One says the main supply is above the power-fail level. The other says the supply is above the battery switch-over level. It also watches the memory's active-low chip-enable, write-enable and output-enable strobes. From these it drives the gated write strobe the array sees, the output tristate control, a write-protect flag and the select between main supply and battery.

While power is good the strobes pass through as for an ordinary static RAM. When the supply sags, an access that is already under way may finish inside a bounded grace window; after that every write is blocked and the outputs float. Once the supply is back, protection holds for a fixed recovery time so the host can settle. A power-up latch keeps the battery disconnected until the supply has been seen good for the first time. All times are parameters counted in clock cycles: DEB_CYC for the flag filter, GRACE_CYC for the grace window and RECOV_CYC for the recovery time.

Top module: `pwr_guard`

## Requirements
- R1: After reset the state code is 2 (protected), wp is 1, bat_link is 0, bat_sel is 0, mem_we_n is 1 and out_hiz is 1.
- R2: In state 0 (normal), strobes are active low. mem_we_n is 0 exactly when ce_n and we_n are both 0. out_hiz is 0 exactly when ce_n is 0, we_n is 1 and oe_n is 0.
- R3: In any state other than 0 or 1 (grace), mem_we_n is 1 and out_hiz is 1 for every value of ce_n, we_n and oe_n.
- R4: When the filtered supply flag falls in state 0, the block enters state 2 if ce_n is 1. If ce_n is 0 it enters state 1, where the strobes still pass. State 1 moves to state 2 on the first clock at which ce_n is 1.
- R5: If ce_n stays 0, state 1 lasts exactly GRACE_CYC clocks before state 2.
- R6: When the filtered supply flag rises in state 2, the block enters state 3 (recovering). It holds state 3 for exactly RECOV_CYC clocks, then enters state 0.
- R7: If the filtered supply flag falls during state 3, the block returns to state 2. The next recovery starts a full RECOV_CYC count.
- R8: The supply flag passes through a two-flop synchronizer and a filter. The filtered flag changes only after the synchronized flag has differed from it for DEB_CYC consecutive clocks. Shorter pulses change neither the state nor the recovery timing.
- R9: In state 2, with bat_link 1 and the battery-level flag low, the block enters state 4 (battery) and bat_sel is 1. When the battery-level flag returns high it goes back to state 2 with bat_sel 0.
- R10: bat_link is 0 until the filtered supply flag is first high, then stays 1 until reset. While bat_link is 0 the block never selects the battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_ok_a | input | 1 | Asynchronous flag: supply above power-fail level |
| sup_hi_a | input | 1 | Asynchronous flag: supply above battery level |
| ce_n | input | 1 | Chip enable from host, active low |
| we_n | input | 1 | Write enable from host, active low |
| oe_n | input | 1 | Output enable from host, active low |
| wp | output | 1 | Write protection active |
| mem_we_n | output | 1 | Gated write strobe to the array, active low |
| out_hiz | output | 1 | 1 = data outputs high impedance |
| bat_sel | output | 1 | 1 = array powered from battery |
| bat_link | output | 1 | Sticky: battery isolation has been broken |
| status | output | 3 | 0 normal, 1 grace, 2 protected, 3 recovering, 4 battery |

## Verification
The hardest situation to reach is a short drop of the supply flag in the middle of a recovery. It must be long enough to pass the synchronizer but shorter than the filter window, and the recovery count must then finish on time. The bench gets there by first waiting until the status port shows recovering. It then counts clocks from that point, inserts a two-clock drop at a fixed offset, and checks that the total time to normal is still RECOV_CYC with no visit to the protected state. A drop that outlasts the filter is applied at the same point to show the timer restarting.

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int DEB_CYC   = 4,
  parameter int GRACE_CYC = 50,
  parameter int RECOV_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok_a,
  input  logic       sup_hi_a,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       wp,
  output logic       mem_we_n,
  output logic       out_hiz,
  output logic       bat_sel,
  output logic       bat_link,
  output logic [2:0] status
);
  localparam int CMAX = (GRACE_CYC > RECOV_CYC) ? GRACE_CYC : RECOV_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int DW   = $clog2(DEB_CYC + 1);

  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_GRACE = 3'd1,
    ST_PROT  = 3'd2,
    ST_RECOV = 3'd3,
    ST_BATT  = 3'd4
  } st_t;

  st_t           state;
  logic [1:0]    ok_sy, hi_sy;
  logic          ok_f;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] cnt;

  wire ok_s = ok_sy[1];
  wire hi_s = hi_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ok_sy <= '0;
      hi_sy <= '0;
    end else begin
      ok_sy <= {ok_sy[0], sup_ok_a};
      hi_sy <= {hi_sy[0], sup_hi_a};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ok_f <= 1'b0;
      dcnt <= '0;
    end else if (ok_s == ok_f) begin
      dcnt <= '0;
    end else if (dcnt == DW'(DEB_CYC - 1)) begin
      ok_f <= ok_s;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bat_link <= 1'b0;
    else if (ok_f) bat_link <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_PROT;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (state)
        ST_NORM:
          if (!ok_f) begin
            state <= ce_n ? ST_PROT : ST_GRACE;
            cnt   <= '0;
          end
        ST_GRACE:
          if (ce_n || cnt == CW'(GRACE_CYC - 1)) state <= ST_PROT;
        ST_PROT:
          if (ok_f) begin
            state <= ST_RECOV;
            cnt   <= '0;
          end else if (!hi_s && bat_link) begin
            state <= ST_BATT;
          end
        ST_RECOV:
          if (!ok_f) state <= ST_PROT;
          else if (cnt == CW'(RECOV_CYC - 1)) state <= ST_NORM;
        ST_BATT:
          if (hi_s) state <= ST_PROT;
        default: state <= ST_PROT;
      endcase
    end

  assign wp       = !(state == ST_NORM || state == ST_GRACE);
  assign mem_we_n = wp | ce_n | we_n;
  assign out_hiz  = wp | ce_n | !we_n | oe_n;
  assign bat_sel  = (state == ST_BATT);
  assign status   = state;

  AST_PROT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (mem_we_n && out_hiz)); // R3
  AST_FALL_LEAVES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM && !ok_f) |=> (state == ST_GRACE || state == ST_PROT)); // R4
  AST_GRACE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRACE) |-> (cnt < CW'(GRACE_CYC))); // R5
  AST_RECOV_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM && $past(state) == ST_RECOV) |-> ($past(cnt) == CW'(RECOV_CYC - 1))); // R6
  AST_RECOV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV && !ok_f) |=> (state == ST_PROT)); // R7
  AST_FILTER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_f != $past(ok_f)) |-> ($past(dcnt) == DW'(DEB_CYC - 1))); // R8
  AST_BATT_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> bat_link); // R10
endmodule

// File: tb/sim_pwr_guard.sv
module sim_pwr_guard;
  localparam int PERIOD = 10;
  localparam int DEB = 4, GRC = 50, REC = 200;

  logic clk = 0, rst_n = 0;
  logic sup_ok_a = 0, sup_hi_a = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic wp, mem_we_n, out_hiz, bat_sel, bat_link;
  logic [2:0] status;
  int total = 0, bad = 0;
  bit done = 0;

  // {ce_n, we_n, oe_n, expected mem_we_n, expected out_hiz}
  localparam logic [4:0] TV [8] = '{
    5'b000_0_1, 5'b001_0_1, 5'b010_1_0, 5'b011_1_1,
    5'b100_1_1, 5'b101_1_1, 5'b110_1_1, 5'b111_1_1 };

  always #(PERIOD/2) clk = ~clk;

  pwr_guard #(.DEB_CYC(DEB), .GRACE_CYC(GRC), .RECOV_CYC(REC)) u0 (
    .clk, .rst_n, .sup_ok_a, .sup_hi_a, .ce_n, .we_n, .oe_n,
    .wp, .mem_we_n, .out_hiz, .bat_sel, .bat_link, .status);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_st(input int exp, input int lim, input string tag);
    int n = 0;
    while (int'(status) != exp && n < lim) begin @(negedge clk); n++; end
    chk(tag, status, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    sup_hi_a = 1; sup_ok_a = 1;
    wait_st(0, REC + 50, "R6 power-up reaches normal");
  endtask

  task automatic power_down();
    ce_n = 1; we_n = 1; oe_n = 1; sup_ok_a = 0;
    wait_st(2, 50, "R4 drop without access");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit saw;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 status", status, 2);
    chk("R1 wp", wp, 1);
    chk("R1 bat_link", bat_link, 0);
    chk("R1 bat_sel", bat_sel, 0);
    chk("R1 mem_we_n", mem_we_n, 1);
    chk("R1 out_hiz", out_hiz, 1);
    cyc(10);
    chk("R10 no battery while isolated", status, 2);
    chk("R10 bat_sel while isolated", bat_sel, 0);

    // R6 exact recovery length
    sup_hi_a = 1; sup_ok_a = 1;
    wait_st(3, 40, "R6 enters recovering");
    n = 0;
    while (status != 0 && n < REC + 20) begin @(negedge clk); n++; end
    chk("R6 recovery cycles", n, REC);
    chk("R10 link set after supply", bat_link, 1);

    // R2 truth table
    foreach (TV[i]) begin
      {ce_n, we_n, oe_n} = TV[i][4:2];
      #1;
      chk("R2 mem_we_n", mem_we_n, TV[i][1]);
      chk("R2 out_hiz", out_hiz, TV[i][0]);
      @(negedge clk);
    end

    // R4 drop with no access
    power_down();

    // R3 all strobe patterns blocked while protected
    for (int i = 0; i < 8; i++) begin
      {ce_n, we_n, oe_n} = 3'(i);
      #1;
      chk("R3 mem_we_n blocked", mem_we_n, 1);
      chk("R3 out_hiz forced", out_hiz, 1);
      @(negedge clk);
    end
    ce_n = 1; we_n = 1; oe_n = 1;

    // R4 write under way enters grace, ends on ce_n rise
    power_up();
    ce_n = 0; we_n = 0; sup_ok_a = 0;
    wait_st(1, 40, "R4 grace entered");
    chk("R4 write passes in grace", mem_we_n, 0);
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(1);
    chk("R4 grace ends with access", status, 2);

    // R5 grace bound
    power_up();
    ce_n = 0; oe_n = 0; sup_ok_a = 0;
    wait_st(1, 40, "R5 grace entered");
    n = 0;
    while (status == 1 && n < GRC + 20) begin @(negedge clk); n++; end
    chk("R5 grace cycles", n, GRC);
    chk("R5 protected after grace", status, 2);
    chk("R3 outputs float after grace", out_hiz, 1);
    ce_n = 1; oe_n = 1;

    // R9 battery select
    sup_hi_a = 0; cyc(4);
    chk("R9 battery state", status, 4);
    chk("R9 bat_sel", bat_sel, 1);
    sup_hi_a = 1; cyc(4);
    chk("R9 back to protected", status, 2);
    chk("R9 bat_sel off", bat_sel, 0);

    // R8 short pulse ignored while protected
    sup_ok_a = 1; cyc(DEB - 2); sup_ok_a = 0; cyc(12);
    chk("R8 short pulse ignored", status, 2);

    // R8 short drop during recovery keeps timing
    sup_ok_a = 1;
    wait_st(3, 40, "R8 enters recovering");
    n = 0; saw = 0;
    while (status != 0 && n < REC + 20) begin
      @(negedge clk); n++;
      if (n == 20) sup_ok_a = 0;
      if (n == 22) sup_ok_a = 1;
      if (status == 2) saw = 1;
    end
    chk("R8 no protect on chatter", saw, 0);
    chk("R8 recovery time unchanged", n, REC);

    // R7 real drop restarts recovery
    power_down();
    sup_ok_a = 1;
    wait_st(3, 40, "R7 enters recovering");
    cyc(50);
    sup_ok_a = 0; cyc(12);
    chk("R7 drop aborts recovery", status, 2);
    sup_ok_a = 1;
    wait_st(3, 40, "R7 recovering again");
    n = 0;
    while (status != 0 && n < REC + 20) begin @(negedge clk); n++; end
    chk("R7 full recovery after restart", n, REC);
    chk("R10 link stays set", bat_link, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule